// File: doc/BRIEF.md
# UART Transmitter with Clear-to-Send Gated Driver Enable

This block serialises bytes onto an asynchronous serial line for half-duplex line drivers. A byte is written into a one-entry holding register. The engine waits until the active-low clear-to-send input, after synchronisation, shows that the far end is ready. It then moves the byte into its shift register, turns on the driver-enable output, waits one full bit time, and sends the frame. After the last stop bit it keeps the driver on for one more clock cycle and then releases it.

The bit time is a programmable number of system clocks. Parity is optional and can be even or odd. The frame can end with one or two stop bits. The polarity of the driver-enable pin is selectable, so both active-high and active-low transceivers can be used. Because the holding register is separate from the shift register, the next byte can be written while the current one is still on the line.

Top module: `uart_de_tx`

## Requirements
- R1: While no character is in progress, `txd` is 1 and `de` is at its inactive level. After reset `txEmpty` is 1.
- R2: `ctsN` is active low and passes through a two-flop synchroniser. A loaded character never starts while `ctsN` is high. When the engine is idle with a byte waiting, `de` turns active at the second rising edge after the first edge that samples `ctsN` low.
- R3: When `deActiveLow` is 0, `de` is 1 while the driver is on and 0 otherwise. When `deActiveLow` is 1, these levels are inverted.
- R4: The start bit (`txd` = 0) begins exactly `baudDiv`+1 clocks after `de` turns active. `txd` stays 1 during that lead time.
- R5: A frame starts with one 0 start bit, followed by 8 data bits with the least significant bit first. Every bit lasts `baudDiv`+1 clocks.
- R6: When `parityEn` is 1, a parity bit follows the data bits. Its value is the XOR of the 8 data bits when `parityOdd` is 0 (even parity), and the inverse of that XOR when `parityOdd` is 1.
- R7: The frame ends with one stop bit of value 1, or two when `twoStop` is 1.
- R8: `de` returns inactive exactly 1 clock after the last stop bit ends. `txd` is 1 during that clock.
- R9: A write with `wrEn` while `txEmpty` is 1 stores `wrData` and clears `txEmpty` at the next edge. `txEmpty` becomes 1 at the edge where the byte moves to the shift register, which is the edge where `de` turns active. A write while the holding register is full is ignored, except in the cycle where the transfer happens; that write is accepted.
- R10: If `ctsN` goes high during a character, that character completes unchanged. The next character does not start until `ctsN` is low again.
- R11: Every character has its own driver-enable bracket. Between back-to-back characters, `de` is inactive for exactly one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| wrEn | input | 1 | Write strobe for the holding register |
| wrData | input | 8 | Byte to send |
| baudDiv | input | 16 | Bit time minus one, in clocks |
| parityEn | input | 1 | Adds a parity bit |
| parityOdd | input | 1 | Selects odd parity (1) or even parity (0) |
| twoStop | input | 1 | Selects two stop bits |
| deActiveLow | input | 1 | Driver-enable pin is active low |
| ctsN | input | 1 | Clear to send, active low, asynchronous |
| txd | output | 1 | Serial data line |
| de | output | 1 | Driver enable |
| txEmpty | output | 1 | Holding register is empty |

## Verification
A write and the holding-to-shift transfer can fall in the same clock edge. The bench provokes this by holding `wrEn` high with a new byte while the register is still full and clear-to-send is then lowered. Every write before the transfer edge must be ignored, and the write in the transfer cycle must be kept. The behavioural model judges this on each clock: it compares `txEmpty` and the order of the two bytes on the line, and it checks that the driver-enable gap between the two frames is a single clock.

// File: rtl/uart_de_pkg.sv
package uart_de_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP1,
    ST_STOP2,
    ST_LAG
  } txState_e;

  typedef enum logic [1:0] {
    LN_MARK,
    LN_START,
    LN_DATA,
    LN_PAR
  } lineSel_e;

  typedef struct packed {
    logic     load;
    logic     shift;
    logic     cntRun;
    lineSel_e lineSel;
  } txStrobe_t;

endpackage

// File: rtl/uart_de_sync.sv
module uart_de_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : gSingle
      always_ff @(posedge clk) begin
        if (rst) chain <= RESET_VAL;
        else     chain <= din;
      end
    end else begin : gMulti
      always_ff @(posedge clk) begin
        if (rst) chain <= {STAGES{RESET_VAL}};
        else     chain <= {chain[STAGES-2:0], din};
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];

endmodule

// File: rtl/uart_de_ctrl.sv
module uart_de_ctrl
  import uart_de_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      ctsSyncN,
  input  logic      holdFull,
  input  logic      baudTick,
  input  logic      lastBit,
  input  logic      parityEn,
  input  logic      twoStop,
  output txStrobe_t stb,
  output logic      deOn
);

  txState_e state, stateNext;

  always_comb begin
    stateNext   = state;
    stb.load    = 1'b0;
    stb.shift   = 1'b0;
    stb.cntRun  = 1'b1;
    stb.lineSel = LN_MARK;
    unique case (state)
      ST_IDLE: begin
        stb.cntRun = 1'b0;
        if (holdFull && !ctsSyncN) begin
          stb.load  = 1'b1;
          stateNext = ST_LEAD;
        end
      end
      ST_LEAD: begin
        if (baudTick) stateNext = ST_START;
      end
      ST_START: begin
        stb.lineSel = LN_START;
        if (baudTick) stateNext = ST_DATA;
      end
      ST_DATA: begin
        stb.lineSel = LN_DATA;
        if (baudTick) begin
          stb.shift = 1'b1;
          if (lastBit) stateNext = parityEn ? ST_PAR : ST_STOP1;
        end
      end
      ST_PAR: begin
        stb.lineSel = LN_PAR;
        if (baudTick) stateNext = ST_STOP1;
      end
      ST_STOP1: begin
        if (baudTick) stateNext = twoStop ? ST_STOP2 : ST_LAG;
      end
      ST_STOP2: begin
        if (baudTick) stateNext = ST_LAG;
      end
      ST_LAG: begin
        stb.cntRun = 1'b0;
        stateNext  = ST_IDLE;
      end
      default: begin
        stb.cntRun = 1'b0;
        stateNext  = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= stateNext;
  end

  assign deOn = (state != ST_IDLE);

  AST_SHIFT_ON_TICK: assert property (@(posedge clk) disable iff (rst)
    stb.shift |-> baudTick); // R5

  AST_LOAD_NEEDS_CTS: assert property (@(posedge clk) disable iff (rst)
    stb.load |-> (!ctsSyncN && holdFull)); // R2

endmodule

// File: rtl/uart_de_dp.sv
module uart_de_dp
  import uart_de_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  txStrobe_t         stb,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DIV_W-1:0]  baudDiv,
  input  logic              parityOdd,
  output logic              txd,
  output logic              holdFull,
  output logic              baudTick,
  output logic              lastBit
);

  localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_W - 1);

  logic [DIV_W-1:0]  baudCnt;
  logic [DATA_W-1:0] holdReg;
  logic [DATA_W-1:0] shiftReg;
  logic [IDX_W-1:0]  bitIdx;
  logic              parityBit;
  logic              wrAccept;

  // bit-time counter, held at zero outside timed states
  assign baudTick = stb.cntRun && (baudCnt == baudDiv);

  always_ff @(posedge clk) begin
    if (rst || !stb.cntRun) baudCnt <= '0;
    else if (baudTick)      baudCnt <= '0;
    else                    baudCnt <= baudCnt + 1'b1;
  end

  // holding register: a write is taken when empty or in the transfer cycle
  assign wrAccept = wrEn && (!holdFull || stb.load);

  always_ff @(posedge clk) begin
    if (rst) begin
      holdFull <= 1'b0;
      holdReg  <= '0;
    end else begin
      if (wrAccept) holdReg <= wrData;
      if (wrAccept)      holdFull <= 1'b1;
      else if (stb.load) holdFull <= 1'b0;
    end
  end

  // shift register, bit index and parity
  always_ff @(posedge clk) begin
    if (rst) begin
      shiftReg  <= '0;
      bitIdx    <= '0;
      parityBit <= 1'b0;
    end else if (stb.load) begin
      shiftReg  <= holdReg;
      bitIdx    <= '0;
      parityBit <= (^holdReg) ^ parityOdd;
    end else if (stb.shift) begin
      shiftReg  <= shiftReg >> 1;
      bitIdx    <= bitIdx + 1'b1;
    end
  end

  assign lastBit = (bitIdx == LAST_IDX);

  always_comb begin
    unique case (stb.lineSel)
      LN_START: txd = 1'b0;
      LN_DATA:  txd = shiftReg[0];
      LN_PAR:   txd = parityBit;
      default:  txd = 1'b1;
    endcase
  end

  AST_LOAD_WHEN_FULL: assert property (@(posedge clk) disable iff (rst)
    stb.load |-> holdFull); // R9

  AST_WRITE_FILLS: assert property (@(posedge clk) disable iff (rst)
    (wrEn && !holdFull) |=> holdFull); // R9

endmodule

// File: rtl/uart_de_tx.sv
module uart_de_tx
  import uart_de_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int DIV_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DIV_W-1:0]  baudDiv,
  input  logic              parityEn,
  input  logic              parityOdd,
  input  logic              twoStop,
  input  logic              deActiveLow,
  input  logic              ctsN,
  output logic              txd,
  output logic              de,
  output logic              txEmpty
);

  txStrobe_t stb;
  logic      ctsSyncN;
  logic      holdFull;
  logic      baudTick;
  logic      lastBit;
  logic      deOn;

  uart_de_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) uSync (
    .clk  (clk),
    .rst  (rst),
    .din  (ctsN),
    .dout (ctsSyncN)
  );

  uart_de_ctrl uCtrl (
    .clk      (clk),
    .rst      (rst),
    .ctsSyncN (ctsSyncN),
    .holdFull (holdFull),
    .baudTick (baudTick),
    .lastBit  (lastBit),
    .parityEn (parityEn),
    .twoStop  (twoStop),
    .stb      (stb),
    .deOn     (deOn)
  );

  uart_de_dp #(.DATA_W(DATA_W), .DIV_W(DIV_W)) uDp (
    .clk       (clk),
    .rst       (rst),
    .stb       (stb),
    .wrEn      (wrEn),
    .wrData    (wrData),
    .baudDiv   (baudDiv),
    .parityOdd (parityOdd),
    .txd       (txd),
    .holdFull  (holdFull),
    .baudTick  (baudTick),
    .lastBit   (lastBit)
  );

  assign de      = deOn ^ deActiveLow;
  assign txEmpty = !holdFull;

  AST_LINE_MARK_IDLE: assert property (@(posedge clk) disable iff (rst)
    !deOn |-> txd); // R1

  AST_LAG_MARK: assert property (@(posedge clk) disable iff (rst)
    $fell(deOn) |-> ($past(txd) && txd)); // R8

  generate
    if (SYNC_STAGES == 2) begin : gCtsCheck
      AST_CTS_BEFORE_DE: assert property (@(posedge clk) disable iff (rst)
        $rose(deOn) |-> !$past(ctsN, 3)); // R2
    end
  endgenerate

endmodule

// File: tb/tb_uart_de_tx.sv
module tb_uart_de_tx;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wrEn = 1'b0;
  logic [7:0]  wrData = '0;
  logic [15:0] baudDiv = 16'd3;
  logic        parityEn = 1'b0;
  logic        parityOdd = 1'b0;
  logic        twoStop = 1'b0;
  logic        deActiveLow = 1'b0;
  logic        ctsN = 1'b1;
  logic        txd, de, txEmpty;

  int checks = 0;
  int errors = 0;

  uart_de_tx dut (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrData(wrData), .baudDiv(baudDiv),
    .parityEn(parityEn), .parityOdd(parityOdd), .twoStop(twoStop),
    .deActiveLow(deActiveLow), .ctsN(ctsN), .txd(txd), .de(de), .txEmpty(txEmpty)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference model
  bit   mS1, mS2, mFull, mBusy, mPar, xfer, fullPre;
  logic [7:0] mHold;
  int   mClk, mB, mN;
  bit   mBits[$];

  always @(posedge clk) begin
    if (rst) begin
      mS1 = 1; mS2 = 1; mFull = 0; mBusy = 0; mClk = 0; mB = 1; mN = 0;
    end else begin
      fullPre = mFull;
      xfer = !mBusy && mFull && !mS2;
      if (mBusy) begin
        mClk++;
        if (mClk > mB * (mN + 1)) mBusy = 0;
      end
      if (xfer) begin
        mBits.delete();
        mBits.push_back(1'b0);
        for (int i = 0; i < 8; i++) mBits.push_back(mHold[i]);
        mPar = parityEn;
        if (parityEn) mBits.push_back((^mHold) ^ parityOdd);
        mBits.push_back(1'b1);
        if (twoStop) mBits.push_back(1'b1);
        mN = mBits.size();
        mB = int'(baudDiv) + 1;
        mBusy = 1; mClk = 0; mFull = 0;
      end
      if (wrEn && (!fullPre || xfer)) begin
        mHold = wrData; mFull = 1;
      end
      mS2 = mS1; mS1 = ctsN;
    end
  end

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: got %0b expected %0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  // per-clock comparison, sampled away from the rising edge
  always begin
    @(posedge clk);
    #(CLK_PERIOD*3/10);
    if (!rst) begin
      logic expTxd, expAct;
      string tag;
      if (!mBusy) begin
        expTxd = 1; expAct = 0; tag = "R1";
      end else if (mClk < mB) begin
        expTxd = 1; expAct = 1; tag = "R4";
      end else if (mClk < mB * (mN + 1)) begin
        int idx;
        idx = (mClk - mB) / mB;
        expTxd = mBits[idx]; expAct = 1;
        if (idx <= 8) tag = "R5";
        else if (idx == 9 && mPar) tag = "R6";
        else tag = "R7";
      end else begin
        expTxd = 1; expAct = 1; tag = "R8";
      end
      chk(tag, "txd", txd, expTxd);
      chk(tag, "de (R3 polarity)", de, expAct ^ deActiveLow);
      chk("R9", "txEmpty", txEmpty, !mFull);
    end
  end

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic writeByte(input logic [7:0] d);
    @(negedge clk); wrEn = 1; wrData = d;
    @(negedge clk); wrEn = 0;
  endtask

  task automatic waitIdle();
    @(negedge clk);
    while (mBusy || mFull) @(negedge clk);
    waitCyc(2);
  endtask

  task automatic sampleAfterEdge();
    @(posedge clk); #(CLK_PERIOD*3/10);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog R1: got hang expected completion at %0t", $time);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    waitCyc(3);
    rst = 0;
    sampleAfterEdge();
    chk("R1", "reset txd", txd, 1'b1);
    chk("R1", "reset de", de, 1'b0);
    chk("R1", "reset txEmpty", txEmpty, 1'b1);

    // byte waits for CTS; a second write while full is ignored (R2, R9)
    writeByte(8'hA5);
    writeByte(8'h3C);
    waitCyc(20);
    chk("R2", "de held off", de, 1'b0);
    chk("R2", "txd held off", txd, 1'b1);
    chk("R9", "txEmpty while full", txEmpty, 1'b0);

    // exact CTS to DE latency (R2)
    @(negedge clk); ctsN = 0;
    sampleAfterEdge();
    sampleAfterEdge();
    chk("R2", "de one edge after sync", de, 1'b0);
    sampleAfterEdge();
    chk("R2", "de after two sync stages", de, 1'b1);
    chk("R9", "txEmpty at transfer", txEmpty, 1'b1);
    waitIdle();
    waitCyc(20);
    chk("R9", "ignored write produced no frame", de, 1'b0);

    // parity even, two stops, active-low DE, one-clock bit time (R3, R6, R7)
    @(negedge clk); parityEn = 1; parityOdd = 0; twoStop = 1; deActiveLow = 1; baudDiv = 0;
    waitCyc(2);
    chk("R3", "active-low idle level", de, 1'b1);
    writeByte(8'h07);
    waitIdle();

    // odd parity, active-high DE, longer bit time (R6)
    @(negedge clk); parityOdd = 1; twoStop = 0; deActiveLow = 0; baudDiv = 5;
    writeByte(8'hFF);
    waitIdle();
    writeByte(8'h80);
    waitIdle();

    // write coinciding with transfer, back-to-back frames (R9, R11)
    @(negedge clk); ctsN = 1; parityEn = 0; baudDiv = 2;
    waitCyc(4);
    writeByte(8'h11);
    @(negedge clk); wrEn = 1; wrData = 8'h22;
    @(negedge clk); ctsN = 0;
    sampleAfterEdge();
    sampleAfterEdge();
    sampleAfterEdge();
    chk("R9", "de at coincident transfer", de, 1'b1);
    chk("R9", "write in transfer cycle kept", txEmpty, 1'b0);
    waitCyc(3);
    wrEn = 0;
    begin
      int guard = 0;
      do begin
        sampleAfterEdge();
        guard++;
      end while (de == 1'b1 && guard < 500);
      chk("R11", "gap between frames", de, 1'b0);
      sampleAfterEdge();
      chk("R11", "next frame bracket", de, 1'b1);
    end
    waitIdle();

    // CTS dropped mid-character (R10)
    @(negedge clk); baudDiv = 4;
    writeByte(8'h5A);
    waitCyc(12);
    ctsN = 1;
    writeByte(8'hC3);
    @(negedge clk);
    while (mBusy) @(negedge clk);
    waitCyc(15);
    chk("R10", "no new frame while CTS high", de, 1'b0);
    chk("R10", "byte still waiting", txEmpty, 1'b0);
    ctsN = 0;
    waitIdle();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule